// File: doc/BRIEF.md
# Integer ALU with Operation Decoder

This block is the integer arithmetic unit of a small load/store processor, together with the combinational decoder that selects its operation. The decoder takes a 2-bit operation class from the main controller and the 6-bit function field of a register-format instruction. From these it forms a 4-bit control word. That word has an invert-A bit, a negate-B bit that also feeds the adder carry-in, and a 2-bit result-select field.

One ripple adder built from replicated 1-bit slices, plus one four-way result mux, produces six operations: AND, OR, add, subtract, NOR and signed set-less-than. Subtraction adds the inverted B with a carry-in of 1. NOR inverts both operands and takes the AND path. Set-less-than takes the sign of A-B and corrects it with the overflow term, so the answer stays right when the difference wraps.

The unit also drives a zero flag, which the processor uses for branch-on-equal after a subtract. It drives a signed overflow flag as well. The overflow flag is only reported; it raises no exception. The unit is purely combinational.

Top module: `int_alu`

## Requirements
- R1: When op_class_i is 00, the unit adds, whatever funct_i holds.
- R2: When op_class_i is 01, the unit subtracts (A-B), whatever funct_i holds.
- R3: When op_class_i[1] is 1, funct_i selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 set-less-than, 100111 NOR.
- R4: When op_class_i[1] is 1 and funct_i holds any other value, the unit performs AND.
- R5: Add returns (A+B) mod 2^32.
- R6: Subtract returns (A-B) mod 2^32.
- R7: AND and OR return the bitwise A&B and A|B.
- R8: NOR returns ~(A|B).
- R9: Set-less-than returns 1 in bit 0 when A is less than B as signed 32-bit integers, and 0 otherwise. Bits 31..1 are always 0. The result is correct even when A-B overflows.
- R10: zero_o is 1 exactly when all 32 bits of result_o are 0, for every operation.
- R11: For add, ovf_o is 1 exactly when A and B have the same sign bit and the sum's sign bit differs from it. Operands of opposite sign never flag.
- R12: For subtract, ovf_o is 1 exactly when A and B differ in sign bit and the difference's sign bit differs from A's.
- R13: ovf_o is 0 for AND, OR, NOR and set-less-than.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_class_i | input | 2 | Operation class from the main controller |
| funct_i | input | 6 | Function field of a register-format instruction |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
On every evaluation, the embedded assertions check several properties:
- The ripple-carry sum matches a behavioural sum or difference.
- NOR matches ~(A|B).
- Set-less-than agrees with a signed compare.
- Adds with opposite-sign operands never flag overflow.
- Subtract overflow follows the operand and result signs.
- The fixed classes 00 and 01 decode to add and subtract.

Other behaviours can only be shown by the bench's scenarios against its reference model. These are:
- the function-field mapping and the AND default for unknown codes;
- the zero flag;
- the overflow flag staying low on the logic operations;
- the full corner grid of 0, 1, -1, the largest positive value and the most negative value.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  // control word: [3] invert a, [2] negate b (also carry-in), [1:0] result select
  localparam int unsigned CTRL_W = 4;
  localparam logic [1:0] SEL_AND = 2'b00;
  localparam logic [1:0] SEL_OR  = 2'b01;
  localparam logic [1:0] SEL_SUM = 2'b10;
  localparam logic [1:0] SEL_LT  = 2'b11;

  localparam logic [CTRL_W-1:0] CTRL_AND = 4'b0000;
  localparam logic [CTRL_W-1:0] CTRL_OR  = 4'b0001;
  localparam logic [CTRL_W-1:0] CTRL_ADD = 4'b0010;
  localparam logic [CTRL_W-1:0] CTRL_SUB = 4'b0110;
  localparam logic [CTRL_W-1:0] CTRL_SLT = 4'b0111;
  localparam logic [CTRL_W-1:0] CTRL_NOR = 4'b1100;

  localparam logic [1:0] CLS_MEM = 2'b00;
  localparam logic [1:0] CLS_BEQ = 2'b01;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
  localparam logic [5:0] FN_NOR = 6'b100111;
endpackage

// File: rtl/alu_op_dec.sv
module alu_op_dec
  import int_alu_pkg::*;
(
  input  logic [1:0]        op_class_i,
  input  logic [5:0]        funct_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] fn_ctrl;

  always_comb begin
    unique case (funct_i)
      FN_ADD:  fn_ctrl = CTRL_ADD;
      FN_SUB:  fn_ctrl = CTRL_SUB;
      FN_AND:  fn_ctrl = CTRL_AND;
      FN_OR:   fn_ctrl = CTRL_OR;
      FN_SLT:  fn_ctrl = CTRL_SLT;
      FN_NOR:  fn_ctrl = CTRL_NOR;
      default: fn_ctrl = CTRL_AND;
    endcase
  end

  always_comb begin
    if (op_class_i[1])              ctrl_o = fn_ctrl;
    else if (op_class_i == CLS_BEQ) ctrl_o = CTRL_SUB;
    else                            ctrl_o = CTRL_ADD;
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic and_o,
  output logic or_o,
  output logic sum_o,
  output logic c_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign sum_o = a_i ^ b_i ^ c_i;
  assign c_o   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              zero_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic             inv_a, neg_b;
  logic [1:0]       sel;
  logic [WIDTH-1:0] a_eff, b_eff, and_v, or_v, sum_v;
  logic [WIDTH:0]   carry;
  logic             raw_ovf, less;

  assign inv_a    = ctrl_i[3];
  assign neg_b    = ctrl_i[2];
  assign sel      = ctrl_i[1:0];
  assign a_eff    = inv_a ? ~a_i : a_i;
  assign b_eff    = neg_b ? ~b_i : b_i;
  assign carry[0] = neg_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .a_i  (a_eff[i]),
      .b_i  (b_eff[i]),
      .c_i  (carry[i]),
      .and_o(and_v[i]),
      .or_o (or_v[i]),
      .sum_o(sum_v[i]),
      .c_o  (carry[i+1])
    );
  end

  // overflow from carries into and out of the sign slice
  assign raw_ovf = carry[WIDTH] ^ carry[MSB];
  // sign corrected for a wrapped difference
  assign less    = sum_v[MSB] ^ raw_ovf;

  always_comb begin
    result_o = '0;
    unique case (sel)
      SEL_AND: result_o = and_v;
      SEL_OR:  result_o = or_v;
      SEL_SUM: result_o = sum_v;
      SEL_LT:  result_o[0] = less;
      default: result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;
  assign ovf_o  = raw_ovf & (sel == SEL_SUM);

  always_comb begin
    if (sel == SEL_SUM && !inv_a) begin
      // R5 R6
      sum_path_chk: assert (result_o == (neg_b ? a_i - b_i : a_i + b_i))
        else $error("sum path mismatch");
    end
    if (ctrl_i == CTRL_NOR) begin
      // R8
      nor_path_chk: assert (result_o == ~(a_i | b_i))
        else $error("nor path mismatch");
    end
    if (ctrl_i == CTRL_SLT) begin
      // R9
      slt_path_chk: assert (result_o == {{MSB{1'b0}}, ($signed(a_i) < $signed(b_i))})
        else $error("slt mismatch");
    end
    if (ctrl_i == CTRL_ADD && (a_i[MSB] != b_i[MSB])) begin
      // R11
      no_overflow_chk: assert (!ovf_o)
        else $error("opposite-sign add flagged overflow");
    end
    if (ctrl_i == CTRL_SUB) begin
      // R12
      sub_overflow_chk: assert (ovf_o == ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
        else $error("subtract overflow mismatch");
    end
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_class_i,
  input  logic [5:0]       funct_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  logic [CTRL_W-1:0] ctrl;

  alu_op_dec u_dec (
    .op_class_i(op_class_i),
    .funct_i   (funct_i),
    .ctrl_o    (ctrl)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .a_i     (a_i),
    .b_i     (b_i),
    .ctrl_i  (ctrl),
    .result_o(result_o),
    .zero_o  (zero_o),
    .ovf_o   (ovf_o)
  );

  always_comb begin
    if (op_class_i == CLS_MEM) begin
      // R1
      mem_class_chk: assert (ctrl == CTRL_ADD) else $error("class 00 not add");
    end
    if (op_class_i == CLS_BEQ) begin
      // R2
      beq_class_chk: assert (ctrl == CTRL_SUB) else $error("class 01 not subtract");
    end
  end
endmodule

// File: tb/int_alu_test.sv
`timescale 1ns/1ps
module int_alu_test;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [1:0]  cls;
  logic [5:0]  fn;
  logic [31:0] result;
  logic        zero, ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] q_res[$];
  logic        q_zero[$];
  logic        q_ovf[$];
  string       q_rtag[$];
  string       q_otag[$];

  always #2.5 clk = ~clk;

  int_alu uut (
    .a_i(a), .b_i(b), .op_class_i(cls), .funct_i(fn),
    .result_o(result), .zero_o(zero), .ovf_o(ovf)
  );

  task automatic drive(input logic [31:0] ta, input logic [31:0] tb,
                       input logic [1:0] tc, input logic [5:0] tf);
    int          op; // 0 and 1 or 2 add 3 sub 4 slt 5 nor
    string       dtag, rtag, otag;
    logic [31:0] er;
    logic        eo;
    if (tc == 2'b00)      begin op = 2; dtag = "R1/"; end
    else if (tc == 2'b01) begin op = 3; dtag = "R2/"; end
    else begin
      dtag = "R3/";
      case (tf)
        6'b100000: op = 2;
        6'b100010: op = 3;
        6'b100100: op = 0;
        6'b100101: op = 1;
        6'b101010: op = 4;
        6'b100111: op = 5;
        default: begin op = 0; dtag = "R4/"; end
      endcase
    end
    eo = 1'b0;
    case (op)
      0: begin er = ta & tb; rtag = "R7"; end
      1: begin er = ta | tb; rtag = "R7"; end
      2: begin er = ta + tb; rtag = "R5";
               eo = (ta[31] == tb[31]) && (er[31] != ta[31]); end
      3: begin er = ta - tb; rtag = "R6";
               eo = (ta[31] != tb[31]) && (er[31] != ta[31]); end
      4: begin er = {31'd0, ($signed(ta) < $signed(tb))}; rtag = "R9"; end
      default: begin er = ~(ta | tb); rtag = "R8"; end
    endcase
    otag = (op == 2) ? "R11" : (op == 3) ? "R12" : "R13";
    @(posedge clk);
    a = ta; b = tb; cls = tc; fn = tf;
    q_res.push_back(er);
    q_zero.push_back(er == 32'd0);
    q_ovf.push_back(eo);
    q_rtag.push_back({dtag, rtag});
    q_otag.push_back(otag);
  endtask

  // monitor: compares half a cycle after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (q_res.size() > 0) begin
        logic [31:0] er;
        logic        ez, eo;
        string       rt, ot;
        er = q_res.pop_front(); ez = q_zero.pop_front(); eo = q_ovf.pop_front();
        rt = q_rtag.pop_front(); ot = q_otag.pop_front();
        checks++;
        if (result !== er) begin
          errors++;
          $display("FAIL %s result a=%h b=%h cls=%b fn=%b got %h exp %h", rt, a, b, cls, fn, result, er);
        end
        checks++;
        if (zero !== ez) begin
          errors++;
          $display("FAIL R10 zero a=%h b=%h got %b exp %b", a, b, zero, ez);
        end
        checks++;
        if (ovf !== eo) begin
          errors++;
          $display("FAIL %s ovf a=%h b=%h cls=%b fn=%b got %b exp %b", ot, a, b, cls, fn, ovf, eo);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [5];
    logic [5:0]  fns [6];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h8000_0000;
    fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100;
    fns[3] = 6'b100101; fns[4] = 6'b101010; fns[5] = 6'b100111;
    a = '0; b = '0; cls = '0; fn = '0;

    // idle inputs: add of zeros, zero flag high (R1 R10)
    drive(32'd0, 32'd0, 2'b00, 6'd0);
    // class 00/01 ignore funct (R1 R2)
    drive(32'h7FFF_FFFF, 32'd1, 2'b00, 6'b100100);
    drive(32'd5, 32'd5, 2'b01, 6'b100101);
    drive(32'h8000_0000, 32'd1, 2'b01, 6'b101010);
    // unknown funct and class 11 (R4 R3)
    drive(32'hF0F0_1234, 32'h0FF0_FFFF, 2'b10, 6'b000000);
    drive(32'hF0F0_1234, 32'h0FF0_FFFF, 2'b11, 6'b111111);
    drive(32'hFFFF_0000, 32'h0000_FFFF, 2'b11, 6'b100111);
    // corner grid over all function codes (R5-R9, R11-R13)
    for (int f = 0; f < 6; f++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(corner[i], corner[j], 2'b10, fns[f]);
    // random operands
    for (int k = 0; k < 600; k++) begin
      logic [31:0] ra, rb;
      logic [1:0]  rc;
      ra = $urandom(); rb = (k % 7 == 0) ? ra : $urandom();
      rc = 2'(k % 4);
      drive(ra, rb, rc, (k % 5 == 0) ? 6'($urandom()) : fns[k % 6]);
    end
    @(posedge clk);
    while (q_res.size() > 0) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule